// File: doc/BRIEF.md
# Execute-Stage ALU with Byte-Lane Constant Loader

This block is the arithmetic and logic unit in the execute stage of a small 32-bit RISC pipeline. The decoder hands it a 5-bit operation code, two operands, a 4-bit shift count or small immediate, the current value of the destination register and the current carry flag. One clock later the unit presents the result, a register write enable, a flag write enable and the zero, carry, negative and overflow flags.

Besides add and subtract (with and without carry), the logic operations, rotates and shifts, move, negate and compare, the unit has four byte-lane loads. Each one places an 8-bit unsigned immediate into one byte of the destination, clears every byte above that lane and keeps every bit below it from the old destination value. A full 32-bit constant is therefore built by issuing the lane-0 load first and then the lane-1, lane-2 and lane-3 loads in turn.

A transfer is accepted on every rising clock edge where `issue` is high. With `issue` low both write enables drop on the next edge and the other outputs keep their values.

Top module: `alu_bytelane_core`

## Requirements
- R1: Code 00000 gives A+B and code 00001 gives A+B+carry_in. The carry flag is the carry out of bit 31. The overflow flag is set when both operands have the same sign and the sign of the result differs from it.
- R2: Code 00010 gives A-B and code 00011 gives A-B-carry_in. After a subtraction the carry flag means a borrow: it is 1 exactly when the unsigned A is less than B (plus carry_in for code 00011). Overflow follows two's-complement subtraction.
- R3: With `use_imm` high, codes 00000 to 00011 use the zero-extended 4-bit `small_amt` as B, and code 10000 uses the zero-extended `src_b[7:0]` as B.
- R4: Codes 00100 AND, 00101 OR, 00110 XOR and 00111 complement of A write their result. They pass carry_in through to the carry flag and clear overflow.
- R5: Codes 01000 to 01011 select byte lane 0 to 3 (lane n is bits 8n+7..8n). They write `src_b[7:0]` into that lane, clear all higher bits and copy all lower bits from `prev_dst`.
- R6: Code 01100 rotates A left, 01101 rotates A right, 01110 shifts A left with zero fill and 01111 shifts A right with sign fill, each by `small_amt` (0 to 15). Carry is passed through and overflow is cleared.
- R7: Code 10000 computes A-B and updates the flags as a subtraction does. It does not write the register (`res_we` = 0, `flag_we` = 1), and `result` shows the difference.
- R8: Code 10101 writes B. Code 10110 writes 0-A with carry = (A != 0) and overflow = (A == 0x80000000). Move passes the carry through and clears overflow.
- R9: Whenever the flags are written, zero is 1 exactly when the 32-bit result is 0, and negative equals bit 31 of the result.
- R10: Outputs change one clock after an edge with `issue` high. After an edge with `issue` low, both enables are 0 and `result` holds its value. Any code not listed above gives `result` = 0, both enables 0, carry = carry_in and overflow = 0.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Internal operation code from the decoder |
| src_a | input | 32 | First operand (A) |
| src_b | input | 32 | Second operand (B); its low byte is the 8-bit immediate |
| small_amt | input | 4 | Shift count or 4-bit immediate |
| use_imm | input | 1 | Selects the immediate form of B |
| prev_dst | input | 32 | Current value of the destination register |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Registered result |
| res_we | output | 1 | Write result to the destination register |
| flag_we | output | 1 | Write the flags |
| zero_f | output | 1 | Zero flag |
| carry_f | output | 1 | Carry / borrow flag |
| neg_f | output | 1 | Negative flag |
| ovf_f | output | 1 | Overflow flag |

## Verification
Every path in this block ends in a single output register, so a wrong operand choice, a wrong shifter stage or a wrong lane multiplexer shows on `result` or the flags exactly one clock after the issuing edge. The bench sweeps every operation code against a grid of boundary operands, including both carry values and both immediate selections, and it sweeps all sixteen shift counts. A stuck shifter stage or a lane that keeps the wrong bits therefore shows up in the first cycle in which it matters. A wrong enable, such as a compare that writes the register or an idle cycle that reports a write, shows on `res_we` or `flag_we` in that same cycle.

// File: rtl/alu_bl_pkg.sv
package alu_bl_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'b00000,
    OP_ADC  = 5'b00001,
    OP_SUB  = 5'b00010,
    OP_SBC  = 5'b00011,
    OP_AND  = 5'b00100,
    OP_OR   = 5'b00101,
    OP_XOR  = 5'b00110,
    OP_NOT  = 5'b00111,
    OP_LDB0 = 5'b01000,
    OP_LDB1 = 5'b01001,
    OP_LDB2 = 5'b01010,
    OP_LDB3 = 5'b01011,
    OP_ROL  = 5'b01100,
    OP_ROR  = 5'b01101,
    OP_LSL  = 5'b01110,
    OP_ASR  = 5'b01111,
    OP_CMP  = 5'b10000,
    OP_MOV  = 5'b10101,
    OP_NEG  = 5'b10110
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_ROL = 2'd0,
    SH_ROR = 2'd1,
    SH_LSL = 2'd2,
    SH_ASR = 2'd3
  } shift_kind_e;

  // signed overflow of a sum, from the sign bits alone
  function automatic logic add_ovf(input logic a_msb, input logic b_msb, input logic r_msb);
    return (a_msb == b_msb) && (r_msb != a_msb);
  endfunction

  // signed overflow of a difference a - b, from the sign bits alone
  function automatic logic sub_ovf(input logic a_msb, input logic b_msb, input logic r_msb);
    return (a_msb != b_msb) && (r_msb != a_msb);
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_bl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         do_sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] wide;
  logic [W:0] cin_ext;

  assign cin_ext = {{W{1'b0}}, cin};

  always_comb begin
    if (do_sub) wide = {1'b0, opa} - {1'b0, opb} - cin_ext;
    else        wide = {1'b0, opa} + {1'b0, opb} + cin_ext;
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = do_sub ? sub_ovf(opa[W-1], opb[W-1], wide[W-1])
                  : add_ovf(opa[W-1], opb[W-1], wide[W-1]);
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_bl_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 4
) (
  input  logic [W-1:0]     din,
  input  logic [AMT_W-1:0] amt,
  input  shift_kind_e      kind,
  output logic [W-1:0]     dout
);
  logic [AMT_W:0][W-1:0] stage;

  assign stage[0] = din;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int DIST = 1 << k;
    logic [W-1:0] moved;
    always_comb begin
      case (kind)
        SH_ROL:  moved = {stage[k][W-DIST-1:0], stage[k][W-1:W-DIST]};
        SH_ROR:  moved = {stage[k][DIST-1:0], stage[k][W-1:DIST]};
        SH_LSL:  moved = {stage[k][W-DIST-1:0], {DIST{1'b0}}};
        default: moved = {{DIST{stage[k][W-1]}}, stage[k][W-1:DIST]};
      endcase
    end
    assign stage[k+1] = amt[k] ? moved : stage[k];
  end

  assign dout = stage[AMT_W];
endmodule

// File: rtl/alu_byteload.sv
module alu_byteload #(
  parameter int W      = 32,
  parameter int LANES  = W / 8,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic [W-9:0]      keep_bits,
  input  logic [7:0]        imm,
  input  logic [LANE_W-1:0] lane,
  output logic [W-1:0]      dout
);
  logic [LANES-1:0][W-1:0] cand;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign cand[g] = {{(W-8){1'b0}}, imm};
    end else if (g == LANES - 1) begin : g_top
      assign cand[g] = {imm, keep_bits[8*g-1:0]};
    end else begin : g_mid
      assign cand[g] = {{(W-8*g-8){1'b0}}, imm, keep_bits[8*g-1:0]};
    end
  end

  assign dout = cand[lane];
endmodule

// File: rtl/alu_bytelane_core.sv
module alu_bytelane_core
  import alu_bl_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [4:0]       op_code,
  input  logic [W-1:0]     src_a,
  input  logic [W-1:0]     src_b,
  input  logic [AMT_W-1:0] small_amt,
  input  logic             use_imm,
  input  logic [W-1:0]     prev_dst,
  input  logic             carry_in,
  output logic [W-1:0]     result,
  output logic             res_we,
  output logic             flag_we,
  output logic             zero_f,
  output logic             carry_f,
  output logic             neg_f,
  output logic             ovf_f
);
  localparam int LANES  = W / 8;
  localparam int LANE_W = $clog2(LANES);

  // operand selection for the shared adder
  logic [W-1:0] imm_small, imm_byte;
  logic [W-1:0] as_a, as_b, as_sum;
  logic         as_sub, as_cin, as_cout, as_ovf;
  logic [W-1:0] sh_out, bl_out;

  // named decode events
  logic ev_addsub, ev_logic, ev_load, ev_shift, ev_cmp, ev_mov, ev_neg;
  logic ev_known;

  logic [W-1:0] nxt_res;
  logic         nxt_we, nxt_fwe, nxt_c, nxt_v;

  assign imm_small = {{(W-AMT_W){1'b0}}, small_amt};
  assign imm_byte  = {{(W-8){1'b0}}, src_b[7:0]};

  assign ev_addsub = (op_code[4:2] == 3'b000);
  assign ev_logic  = (op_code[4:2] == 3'b001);
  assign ev_load   = (op_code[4:2] == 3'b010);
  assign ev_shift  = (op_code[4:2] == 3'b011);
  assign ev_cmp    = (op_code == OP_CMP);
  assign ev_mov    = (op_code == OP_MOV);
  assign ev_neg    = (op_code == OP_NEG);
  assign ev_known  = ev_addsub | ev_logic | ev_load | ev_shift | ev_cmp | ev_mov | ev_neg;

  always_comb begin
    as_a   = ev_neg ? '0 : src_a;
    as_sub = (ev_addsub & op_code[1]) | ev_cmp | ev_neg;
    as_cin = ev_addsub & op_code[0] & carry_in;
    if (ev_neg)      as_b = src_a;
    else if (ev_cmp) as_b = use_imm ? imm_byte : src_b;
    else             as_b = use_imm ? imm_small : src_b;
  end

  alu_addsub #(.W(W)) u_addsub (
    .opa    (as_a),
    .opb    (as_b),
    .do_sub (as_sub),
    .cin    (as_cin),
    .sum    (as_sum),
    .cout   (as_cout),
    .ovf    (as_ovf)
  );

  alu_shifter #(.W(W), .AMT_W(AMT_W)) u_shifter (
    .din  (src_a),
    .amt  (small_amt),
    .kind (shift_kind_e'(op_code[1:0])),
    .dout (sh_out)
  );

  alu_byteload #(.W(W), .LANES(LANES), .LANE_W(LANE_W)) u_byteload (
    .keep_bits (prev_dst[W-9:0]),
    .imm       (src_b[7:0]),
    .lane      (op_code[LANE_W-1:0]),
    .dout      (bl_out)
  );

  always_comb begin
    nxt_res = '0;
    nxt_we  = 1'b0;
    nxt_fwe = ev_known;
    nxt_c   = carry_in;
    nxt_v   = 1'b0;
    if (ev_addsub || ev_cmp || ev_neg) begin
      nxt_res = as_sum;
      nxt_we  = !ev_cmp;
      nxt_c   = as_cout;
      nxt_v   = as_ovf;
    end else if (ev_logic) begin
      nxt_we = 1'b1;
      case (op_code)
        OP_AND:  nxt_res = src_a & src_b;
        OP_OR:   nxt_res = src_a | src_b;
        OP_XOR:  nxt_res = src_a ^ src_b;
        default: nxt_res = ~src_a;
      endcase
    end else if (ev_load) begin
      nxt_we  = 1'b1;
      nxt_res = bl_out;
    end else if (ev_shift) begin
      nxt_we  = 1'b1;
      nxt_res = sh_out;
    end else if (ev_mov) begin
      nxt_we  = 1'b1;
      nxt_res = src_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      res_we  <= 1'b0;
      flag_we <= 1'b0;
      zero_f  <= 1'b0;
      carry_f <= 1'b0;
      neg_f   <= 1'b0;
      ovf_f   <= 1'b0;
    end else if (issue) begin
      result  <= nxt_res;
      res_we  <= nxt_we;
      flag_we <= nxt_fwe;
      zero_f  <= (nxt_res == '0);
      carry_f <= nxt_c;
      neg_f   <= nxt_res[W-1];
      ovf_f   <= nxt_v;
    end else begin
      res_we  <= 1'b0;
      flag_we <= 1'b0;
    end
  end
endmodule

// File: rtl/alu_bl_checker.sv
module alu_bl_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         issue,
  input logic [4:0]   op_code,
  input logic [W-1:0] src_b,
  input logic [W-1:0] prev_dst,
  input logic         carry_in,
  input logic [W-1:0] result,
  input logic         res_we,
  input logic         flag_we,
  input logic         zero_f,
  input logic         carry_f,
  input logic         neg_f,
  input logic         ovf_f
);
  p_cmp_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_code == 5'b10000 |=> !res_we && flag_we);

  p_logic_keeps_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_code[4:2] == 3'b001 |=> carry_f == $past(carry_in) && !ovf_f);

  p_shift_keeps_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_code[4:2] == 3'b011 |=> carry_f == $past(carry_in) && !ovf_f);

  p_lane0_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_code == 5'b01000 |=> result[W-1:8] == '0 && result[7:0] == $past(src_b[7:0]));

  p_lane3_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_code == 5'b01011 |=> result[W-9:0] == $past(prev_dst[W-9:0]));

  p_flags_follow_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> zero_f == (result == '0) && neg_f == result[W-1]);

  p_idle_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !res_we && !flag_we && $stable(result));
endmodule

bind alu_bytelane_core alu_bl_checker #(.W(W)) u_alu_bl_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .issue    (issue),
  .op_code  (op_code),
  .src_b    (src_b),
  .prev_dst (prev_dst),
  .carry_in (carry_in),
  .result   (result),
  .res_we   (res_we),
  .flag_we  (flag_we),
  .zero_f   (zero_f),
  .carry_f  (carry_f),
  .neg_f    (neg_f),
  .ovf_f    (ovf_f)
);

// File: tb/test_alu_bytelane_core.sv
module test_alu_bytelane_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [4:0]  op_code;
  logic [31:0] src_a, src_b, prev_dst;
  logic [3:0]  small_amt;
  logic        use_imm, carry_in;
  logic [31:0] result;
  logic        res_we, flag_we, zero_f, carry_f, neg_f, ovf_f;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] pat [10];

  always #10 clk = ~clk;

  alu_bytelane_core i_alu_bytelane_core (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .small_amt(small_amt), .use_imm(use_imm),
    .prev_dst(prev_dst), .carry_in(carry_in), .result(result),
    .res_we(res_we), .flag_we(flag_we), .zero_f(zero_f), .carry_f(carry_f),
    .neg_f(neg_f), .ovf_f(ovf_f)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (op %b a %h b %h amt %0d imm %0b cin %0b)",
               tag, what, act, exp, op_code, src_a, src_b, small_amt, use_imm, carry_in);
    end
  endtask

  function automatic string tag_of(input logic [4:0] op, input logic imm);
    if (imm && (op[4:2] == 3'b000 || op == 5'b10000)) return "R3";
    if (op[4:1] == 4'b0000) return "R1";
    if (op[4:1] == 4'b0001) return "R2";
    if (op[4:2] == 3'b001)  return "R4";
    if (op[4:2] == 3'b010)  return "R5";
    if (op[4:2] == 3'b011)  return "R6";
    if (op == 5'b10000)     return "R7";
    if (op == 5'b10101 || op == 5'b10110) return "R8";
    return "R10";
  endfunction

  // expected behaviour, written from the requirements with wide integer arithmetic
  task automatic model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b_in,
                       input logic [3:0] amt, input logic imm, input logic [31:0] prev,
                       input logic cin, output logic [31:0] res, output logic we,
                       output logic fwe, output logic c, output logic v);
    logic [63:0] b, cu, t, dbl;
    longint sa, sb, sr;
    b  = {32'd0, b_in};
    cu = 64'(cin);
    res = '0; we = 1'b0; fwe = 1'b1; c = cin; v = 1'b0;
    if (op[4:2] == 3'b000 || op == 5'b10000) begin
      if (op == 5'b10000) b = imm ? {56'd0, b_in[7:0]} : {32'd0, b_in};
      else if (imm)       b = {60'd0, amt};
      if (op == 5'b10000 || !op[0]) cu = 64'd0;
      sa = longint'($signed(a));
      sb = longint'($signed(b[31:0]));
      if (op[4:1] == 4'b0000) begin
        t = {32'd0, a} + b + cu;
        res = t[31:0]; c = t[32];
        sr = sa + sb + longint'(cu);
      end else begin
        t = {32'd0, a} - b - cu;
        res = t[31:0]; c = ({32'd0, a} < b + cu);
        sr = sa - sb - longint'(cu);
      end
      v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      we = (op != 5'b10000);
    end else if (op[4:2] == 3'b001) begin
      we = 1'b1;
      case (op[1:0])
        2'd0: res = a & b_in;
        2'd1: res = a | b_in;
        2'd2: res = a ^ b_in;
        default: res = ~a;
      endcase
    end else if (op[4:2] == 3'b010) begin
      we = 1'b1;
      t = ({32'd0, prev} & ((64'd1 << (8 * op[1:0])) - 64'd1)) | ({56'd0, b_in[7:0]} << (8 * op[1:0]));
      res = t[31:0];
    end else if (op[4:2] == 3'b011) begin
      we = 1'b1;
      dbl = {a, a};
      case (op[1:0])
        2'd0: begin t = dbl << amt; res = t[63:32]; end
        2'd1: begin t = dbl >> amt; res = t[31:0]; end
        2'd2: res = a << amt;
        default: res = $signed(a) >>> amt;
      endcase
    end else if (op == 5'b10101) begin
      we = 1'b1; res = b_in;
    end else if (op == 5'b10110) begin
      we = 1'b1; res = 32'd0 - a;
      c = (a != 0); v = (a == 32'h8000_0000);
    end else begin
      fwe = 1'b0;
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (one register stage)
  task automatic run_vec(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [3:0] amt, input logic imm, input logic [31:0] prev,
                         input logic cin);
    logic [31:0] e_res;
    logic e_we, e_fwe, e_c, e_v;
    string tg;
    issue = 1'b1; op_code = op; src_a = a; src_b = b; small_amt = amt;
    use_imm = imm; prev_dst = prev; carry_in = cin;
    model(op, a, b, amt, imm, prev, cin, e_res, e_we, e_fwe, e_c, e_v);
    tg = tag_of(op, imm);
    @(negedge clk);
    check(tg, "result/enables", {result[31:2] ^ {28'd0, res_we, flag_we}, result[1:0]},
          {e_res[31:2] ^ {28'd0, e_we, e_fwe}, e_res[1:0]});
    check(tg, "carry/overflow", {30'd0, carry_f, ovf_f}, {30'd0, e_c, e_v});
    check("R9", "zero/negative", {30'd0, zero_f, neg_f}, {30'd0, (e_res == 0), e_res[31]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    pat = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
            32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_FFFF, 32'h0000_0010, 32'hA5A5_A5A5};
    rst_n = 1'b0; issue = 1'b1; op_code = 5'b00000; src_a = 32'hFFFF_FFFF;
    src_b = 32'h1; small_amt = 4'd3; use_imm = 1'b0; prev_dst = '0; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state with active stimulus
    check("R11", "reset outputs", result, 32'd0);
    check("R11", "reset enables/flags",
          {25'd0, res_we, flag_we, zero_f, carry_f, neg_f, ovf_f, 1'b0}, 32'd0);
    rst_n = 1'b1;

    // main sweep: every op code over an operand grid
    for (int op = 0; op < 32; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          for (int m = 0; m < 4; m++)
            run_vec(5'(op), pat[i], pat[j], 4'((i * 7 + j * 3 + m * 5) % 16), m[0],
                    pat[(i + j + 3) % 10] ^ 32'h3C3C_3C3C, m[1]);

    // every shift amount for every shift kind (R6)
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 16; s++)
        for (int i = 0; i < 10; i++)
          run_vec(5'(12 + k), pat[i], pat[9 - i], 4'(s), 1'b0, 32'h0, 1'(s % 2));

    // R5: build a constant lane by lane starting from the low byte
    run_vec(5'b01000, 32'h0, 32'hAB, 4'd0, 1'b0, 32'hFFFF_FFFF, 1'b0);
    run_vec(5'b01001, 32'h0, 32'hCD, 4'd0, 1'b0, result, 1'b0);
    run_vec(5'b01010, 32'h0, 32'hEF, 4'd0, 1'b0, result, 1'b0);
    run_vec(5'b01011, 32'h0, 32'h12, 4'd0, 1'b0, result, 1'b0);
    check("R5", "constant built", result, 32'h12EF_CDAB);

    // R8: negate of the most negative value
    run_vec(5'b10110, 32'h8000_0000, 32'h0, 4'd0, 1'b0, 32'h0, 1'b0);

    // R10: idle cycle keeps result and drops enables
    run_vec(5'b00101, 32'h0F0F_0000, 32'h0000_00F0, 4'd0, 1'b0, 32'h0, 1'b0);
    held = result;
    issue = 1'b0; op_code = 5'b00000; src_a = 32'h5; src_b = 32'h7;
    @(negedge clk);
    check("R10", "idle result held", result, held);
    check("R10", "idle enables", {30'd0, res_we, flag_we}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule